// File: doc/BRIEF.md
# Segment Descriptor Access Checker

This block judges a single access made through a code or data segment descriptor that has already been fetched. It takes the descriptor's attribute byte, its three flag bits and its 20-bit limit, together with the requester's current privilege level, the kind of access, the starting byte offset and the access length. It answers with allow or fault, a prioritised cause code, the privilege level that holds after a far jump, and a request to set the descriptor's accessed bit in memory.

The limit is scaled by the granularity flag. Expand-down data segments invert the valid range, and conforming code segments relax the privilege match on far jumps. By default the result is registered and appears one clock after the request strobe. A parameter can make the stage purely combinational.

Top module: `seg_access_check`

## Requirements
- R1: With `gran`=0 the effective limit equals `limit`. With `gran`=1 it is `limit`*4096 + 4095.
- R2: Except for expand-down data segments, the access covers bytes `offset` through `offset`+`len`. It raises a limit fault (cause 5) when that last byte, computed without wrap, exceeds the effective limit.
- R3: A data segment with attribute bit 2 set is expand-down. The access is in bounds only when `offset` is strictly above the effective limit and the last byte does not exceed the upper bound. The upper bound is 0xFFFF when `size32`=0 and 0xFFFFFFFF when `size32`=1. Otherwise the cause is 5.
- R4: A code segment (attribute bit 4 = 1, bit 3 = 1) has these type rules (cause 3). A write always faults. A read faults unless bit 1 is set. Execute and far jump (`kind` 2 and 3) are only legal on code segments. A system descriptor (bit 4 = 0) always faults with cause 3.
- R5: A data segment (bit 4 = 1, bit 3 = 0) is always readable. A write faults with cause 3 unless bit 1 is set.
- R6: A far jump into a non-conforming code segment (bit 2 = 0) faults with cause 4 unless `cpl` equals the descriptor level in bits 6:5.
- R7: A far jump into a conforming code segment (bit 2 = 1) faults with cause 4 when `cpl` is numerically below the descriptor level. When any access is allowed, `rsp_new_cpl` equals the requesting `cpl`.
- R8: The descriptor is malformed (cause 2) if `long_code`=1 together with `size32`=1, or if `long_code`=1 on a data segment.
- R9: A descriptor with bit 7 (present) clear faults with cause 1.
- R10: Only one cause is reported, chosen in this order: 1, 2, 3, 4, 5. Cause 0 means allowed, and `rsp_allow` is 1 exactly when the cause is 0.
- R11: `rsp_set_acc` is 1 only when the access is allowed and attribute bit 0 (accessed) was 0.
- R12: The `kind` encoding is 0 read, 1 write, 2 execute, 3 far jump. `rsp_valid` rises one clock after each `req_valid` cycle and at no other time. It is 0 during and right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| acc_byte | input | 8 | Descriptor attribute byte: present, level, segment, code, dir/conforming, read/write, accessed |
| gran | input | 1 | Limit granularity flag |
| size32 | input | 1 | Default operand size flag |
| long_code | input | 1 | 64-bit code flag |
| limit | input | 20 | Raw segment limit |
| cpl | input | 2 | Current privilege level |
| kind | input | 2 | Access kind |
| offset | input | 32 | First byte offset |
| len | input | 3 | Access length minus one |
| rsp_valid | output | 1 | Result valid |
| rsp_allow | output | 1 | Access allowed |
| rsp_cause | output | 3 | Fault cause code |
| rsp_new_cpl | output | 2 | Privilege level after the access |
| rsp_set_acc | output | 1 | Write back the accessed bit |

## Verification
The bench targets limit edges at exactly the effective limit and one past it, with page granularity on and off. It probes expand-down segments at the limit and across the 16-bit upper bound. A design that compares only the first byte, or that uses a non-strict compare on expand-down, passes or faults the wrong byte there. Descriptors carrying several faults at once show whether the cause priority has been swapped. Conforming and non-conforming jumps from each side of the descriptor level catch an inverted privilege test. Accessed-bit cases with faults show whether write-back is requested when it must not be.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
   typedef enum logic [1:0] {
      ACC_READ   = 2'd0,
      ACC_WRITE  = 2'd1,
      ACC_EXEC   = 2'd2,
      ACC_FARJMP = 2'd3
   } acc_kind_e;

   typedef enum logic [2:0] {
      FLT_NONE      = 3'd0,
      FLT_ABSENT    = 3'd1,
      FLT_MALFORMED = 3'd2,
      FLT_TYPE      = 3'd3,
      FLT_PRIV      = 3'd4,
      FLT_LIMIT     = 3'd5
   } fault_e;

   // attribute byte bit positions
   localparam int AB_PRESENT  = 7;
   localparam int AB_LVL_HI   = 6;
   localparam int AB_LVL_LO   = 5;
   localparam int AB_SEGMENT  = 4;
   localparam int AB_CODE     = 3;
   localparam int AB_DIRCONF  = 2;
   localparam int AB_RDWR     = 1;
   localparam int AB_ACCESSED = 0;
endpackage

// File: rtl/seg_limit_unit.sv
module seg_limit_unit #(
   parameter int ADDR_W     = 32,
   parameter int LIM_W      = 20,
   parameter int GRAN_SHIFT = 12,
   parameter int LEN_W      = 3,
   parameter int SMALL_W    = 16
) (
   input  logic [LIM_W-1:0]  limit,
   input  logic              gran,
   input  logic              size32,
   input  logic              expand_down,
   input  logic [ADDR_W-1:0] offset,
   input  logic [LEN_W-1:0]  len,
   output logic              in_bounds
);
   localparam int EXT_W    = ADDR_W + 1;
   localparam int SCALED_W = LIM_W + GRAN_SHIFT;

   if (ADDR_W < SCALED_W) begin : g_bad_scale
      $error("seg_limit_unit: ADDR_W too small for scaled limit");
   end
   if (SMALL_W > ADDR_W) begin : g_bad_small
      $error("seg_limit_unit: SMALL_W exceeds ADDR_W");
   end

   logic [ADDR_W-1:0] eff_lim;
   logic [EXT_W-1:0]  last_byte;
   logic [EXT_W-1:0]  upper;
   logic              up_ok;
   logic              dn_ok;

   always_comb begin
      eff_lim = '0;
      if (gran) eff_lim[SCALED_W-1:0] = {limit, {GRAN_SHIFT{1'b1}}};
      else      eff_lim[LIM_W-1:0]    = limit;
   end

   assign last_byte = {1'b0, offset} + EXT_W'(len);
   assign upper     = size32 ? {1'b0, {ADDR_W{1'b1}}} : EXT_W'({SMALL_W{1'b1}});
   assign up_ok     = last_byte <= {1'b0, eff_lim};
   assign dn_ok     = (offset > eff_lim) && (last_byte <= upper);
   assign in_bounds = expand_down ? dn_ok : up_ok;
endmodule

// File: rtl/seg_rights_unit.sv
module seg_rights_unit
   import seg_chk_pkg::*;
(
   input  logic [6:1] attr,
   input  logic       long_code,
   input  logic       size32,
   input  logic [1:0] cpl,
   input  logic [1:0] kind,
   output logic       malformed,
   output logic       type_bad,
   output logic       priv_bad,
   output logic       expand_down,
   output logic [1:0] new_cpl
);
   logic       seg, code, dc, rw;
   logic [1:0] dpl;
   logic       is_data;

   assign seg     = attr[AB_SEGMENT];
   assign code    = attr[AB_CODE];
   assign dc      = attr[AB_DIRCONF];
   assign rw      = attr[AB_RDWR];
   assign dpl     = attr[AB_LVL_HI:AB_LVL_LO];
   assign is_data = seg & ~code;

   assign malformed   = long_code & (size32 | is_data);
   assign expand_down = is_data & dc;

   always_comb begin
      type_bad = 1'b0;
      if (!seg) begin
         type_bad = 1'b1;
      end else if (code) begin
         case (kind)
            ACC_WRITE: type_bad = 1'b1;
            ACC_READ:  type_bad = ~rw;
            default:   type_bad = 1'b0;
         endcase
      end else begin
         case (kind)
            ACC_WRITE: type_bad = ~rw;
            ACC_READ:  type_bad = 1'b0;
            default:   type_bad = 1'b1;
         endcase
      end
   end

   always_comb begin
      priv_bad = 1'b0;
      new_cpl  = cpl;
      if (kind == ACC_FARJMP && seg && code) begin
         if (dc) begin
            priv_bad = cpl < dpl;
         end else begin
            priv_bad = cpl != dpl;
            new_cpl  = dpl;
         end
      end
   end
endmodule

// File: rtl/seg_fault_pick.sv
module seg_fault_pick
   import seg_chk_pkg::*;
(
   input  logic       absent,
   input  logic       malformed,
   input  logic       type_bad,
   input  logic       priv_bad,
   input  logic       limit_bad,
   output logic [2:0] cause,
   output logic       allow
);
   always_comb begin
      if (absent)         cause = FLT_ABSENT;
      else if (malformed) cause = FLT_MALFORMED;
      else if (type_bad)  cause = FLT_TYPE;
      else if (priv_bad)  cause = FLT_PRIV;
      else if (limit_bad) cause = FLT_LIMIT;
      else                cause = FLT_NONE;
   end
   assign allow = ~(absent | malformed | type_bad | priv_bad | limit_bad);
endmodule

// File: rtl/seg_access_check.sv
module seg_access_check
   import seg_chk_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LIM_W      = 20,
   parameter int GRAN_SHIFT = 12,
   parameter int LEN_W      = 3,
   parameter bit REG_OUT    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [7:0]        acc_byte,
   input  logic              gran,
   input  logic              size32,
   input  logic              long_code,
   input  logic [LIM_W-1:0]  limit,
   input  logic [1:0]        cpl,
   input  logic [1:0]        kind,
   input  logic [ADDR_W-1:0] offset,
   input  logic [LEN_W-1:0]  len,
   output logic              rsp_valid,
   output logic              rsp_allow,
   output logic [2:0]        rsp_cause,
   output logic [1:0]        rsp_new_cpl,
   output logic              rsp_set_acc
);
   if (LEN_W < 1 || LEN_W > 8) begin : g_bad_len
      $error("seg_access_check: LEN_W out of range");
   end

   logic       malformed, type_bad, priv_bad, expand_down, in_bounds;
   logic [1:0] c_cpl;
   logic [2:0] c_cause;
   logic       c_allow, c_set;

   seg_rights_unit u_rights (
      .attr(acc_byte[6:1]), .long_code(long_code), .size32(size32),
      .cpl(cpl), .kind(kind), .malformed(malformed), .type_bad(type_bad),
      .priv_bad(priv_bad), .expand_down(expand_down), .new_cpl(c_cpl)
   );

   seg_limit_unit #(
      .ADDR_W(ADDR_W), .LIM_W(LIM_W), .GRAN_SHIFT(GRAN_SHIFT), .LEN_W(LEN_W)
   ) u_limit (
      .limit(limit), .gran(gran), .size32(size32), .expand_down(expand_down),
      .offset(offset), .len(len), .in_bounds(in_bounds)
   );

   seg_fault_pick u_pick (
      .absent(~acc_byte[AB_PRESENT]), .malformed(malformed), .type_bad(type_bad),
      .priv_bad(priv_bad), .limit_bad(~in_bounds), .cause(c_cause), .allow(c_allow)
   );

   assign c_set = c_allow & ~acc_byte[AB_ACCESSED];

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_allow   <= 1'b0;
            rsp_cause   <= 3'd0;
            rsp_new_cpl <= 2'd0;
            rsp_set_acc <= 1'b0;
         end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
               rsp_allow   <= c_allow;
               rsp_cause   <= c_cause;
               rsp_new_cpl <= c_cpl;
               rsp_set_acc <= c_set;
            end
         end
      end

      p_lat_r12: assert property (@(posedge clk) disable iff (!rst_n)
         rsp_valid |-> $past(req_valid));
      p_lat_back_r12: assert property (@(posedge clk) disable iff (!rst_n)
         $past(req_valid) |-> rsp_valid);
      p_absent_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && !$past(acc_byte[AB_PRESENT])) |-> rsp_cause == FLT_ABSENT);
      p_code_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && $past(kind == ACC_WRITE && acc_byte[AB_SEGMENT] && acc_byte[AB_CODE]))
         |-> !rsp_allow);
      p_malformed_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && $past(acc_byte[AB_PRESENT] && long_code && size32))
         |-> rsp_cause == FLT_MALFORMED);
      p_wb_r11: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && rsp_set_acc) |-> (rsp_allow && !$past(acc_byte[AB_ACCESSED])));
      p_keep_cpl_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (rsp_valid && rsp_allow) |-> rsp_new_cpl == $past(cpl));
   end else begin : g_comb
      assign rsp_valid   = req_valid;
      assign rsp_allow   = c_allow;
      assign rsp_cause   = c_cause;
      assign rsp_new_cpl = c_cpl;
      assign rsp_set_acc = c_set;
   end
endmodule

// File: tb/sim_seg_access_check.sv
module sim_seg_access_check;
   localparam time CLK_PERIOD = 10ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [7:0]  acc_byte = '0;
   logic        gran = 1'b0, size32 = 1'b0, long_code = 1'b0;
   logic [19:0] limit = '0;
   logic [1:0]  cpl = '0, kind = '0;
   logic [31:0] offset = '0;
   logic [2:0]  len = '0;
   logic        rsp_valid, rsp_allow, rsp_set_acc;
   logic [2:0]  rsp_cause;
   logic [1:0]  rsp_new_cpl;

   seg_access_check u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .acc_byte(acc_byte),
      .gran(gran), .size32(size32), .long_code(long_code), .limit(limit),
      .cpl(cpl), .kind(kind), .offset(offset), .len(len),
      .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_cause(rsp_cause),
      .rsp_new_cpl(rsp_new_cpl), .rsp_set_acc(rsp_set_acc)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   typedef struct {
      logic       allow;
      logic [2:0] cause;
      logic [1:0] cpl;
      logic       wb;
      string      tag;
      int         cyc;
   } item_t;

   item_t q[$];
   int n_chk = 0, n_bad = 0, cyc = 0;
   bit done = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [7:0] mk(bit p, bit [1:0] d, bit s, bit e, bit dc, bit rw, bit a);
      return {p, d, s, e, dc, rw, a};
   endfunction

   // reference model written from the requirements
   function automatic item_t model(logic [7:0] ab, bit g, bit db, bit l, logic [19:0] lim,
                                   logic [1:0] c, logic [1:0] k, logic [31:0] off, logic [2:0] ln);
      item_t r;
      longint effl, last, top;
      bit s = ab[4], e = ab[3], dc = ab[2], rw = ab[1];
      bit tbad, pbad, lbad;
      effl = g ? ((longint'(lim) * 4096) + 4095) : longint'(lim);
      last = longint'(off) + longint'(ln);
      top  = db ? 64'hFFFF_FFFF : 64'hFFFF;
      if (!s)     tbad = 1;
      else if (e) tbad = (k == 1) || (k == 0 && !rw);
      else        tbad = (k == 1 && !rw) || (k >= 2);
      pbad = 0;
      if (k == 3 && s && e) pbad = dc ? (c < ab[6:5]) : (c != ab[6:5]);
      if (s && !e && dc) lbad = !(longint'(off) > effl && last <= top);
      else               lbad = last > effl;
      if (!ab[7])                          r.cause = 1;
      else if (l && (db || (s && !e)))     r.cause = 2;
      else if (tbad)                       r.cause = 3;
      else if (pbad)                       r.cause = 4;
      else if (lbad)                       r.cause = 5;
      else                                 r.cause = 0;
      r.allow = (r.cause == 0);
      r.cpl   = c;
      r.wb    = r.allow && !ab[0];
      return r;
   endfunction

   task automatic drive(logic [7:0] ab, bit g, bit db, bit l, logic [19:0] lim,
                        logic [1:0] c, logic [1:0] k, logic [31:0] off, logic [2:0] ln, string tag);
      item_t it;
      @(negedge clk);
      acc_byte = ab; gran = g; size32 = db; long_code = l; limit = lim;
      cpl = c; kind = k; offset = off; len = ln; req_valid = 1'b1;
      it = model(ab, g, db, l, lim, c, k, off, ln);
      it.tag = tag;
      it.cyc = cyc;
      q.push_back(it);
   endtask

   task automatic idle(int n);
      @(negedge clk);
      req_valid = 1'b0;
      repeat (n) @(negedge clk);
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done && rsp_valid) begin
         item_t e;
         n_chk++;
         if (q.size() == 0) begin
            n_bad++;
            $display("FAIL R12 unexpected rsp_valid: actual 1 expected 0");
         end else begin
            e = q.pop_front();
            if (cyc != e.cyc + 1 || rsp_allow !== e.allow || rsp_cause !== e.cause ||
                rsp_set_acc !== e.wb || (e.allow && rsp_new_cpl !== e.cpl)) begin
               n_bad++;
               $display("FAIL %s actual allow=%0b cause=%0d cpl=%0d wb=%0b cyc=%0d expected allow=%0b cause=%0d cpl=%0d wb=%0b cyc=%0d",
                        e.tag, rsp_allow, rsp_cause, rsp_new_cpl, rsp_set_acc, cyc,
                        e.allow, e.cause, e.cpl, e.wb, e.cyc + 1);
            end
         end
      end
   end

   task automatic summary();
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired: actual running expected finished");
      summary();
   end

   localparam logic [7:0] DATA_RW  = 8'b1001_0010; // present, level 0, data, writable
   localparam logic [7:0] CODE_RD  = 8'b1001_1010; // present, level 0, code, readable

   initial begin
      repeat (3) @(negedge clk);
      n_chk++;
      if (rsp_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R12 reset rsp_valid: actual %0b expected 0", rsp_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if (rsp_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R12 after reset rsp_valid: actual %0b expected 0", rsp_valid);
      end

      // R1 page granularity
      drive(DATA_RW, 1, 1, 0, 20'h1, 0, 0, 32'h1FFF, 0, "R1");
      drive(DATA_RW, 1, 1, 0, 20'h1, 0, 0, 32'h2000, 0, "R1");
      drive(DATA_RW, 0, 1, 0, 20'h1, 0, 0, 32'h2, 0, "R1");
      // R2 last byte of a multi-byte access
      drive(DATA_RW, 0, 1, 0, 20'h10, 0, 0, 32'hF, 1, "R2");
      drive(DATA_RW, 0, 1, 0, 20'h10, 0, 0, 32'h10, 1, "R2");
      drive(CODE_RD, 0, 1, 0, 20'h10, 0, 2, 32'h10, 0, "R2");
      drive(DATA_RW, 1, 1, 0, 20'hFFFFF, 0, 0, 32'hFFFF_FFFF, 1, "R2");
      idle(2);
      // R3 expand-down
      drive(mk(1,0,1,0,1,1,1), 0, 0, 0, 20'h0FFF, 0, 0, 32'h0FFF, 0, "R3");
      drive(mk(1,0,1,0,1,1,1), 0, 0, 0, 20'h0FFF, 0, 0, 32'h1000, 0, "R3");
      drive(mk(1,0,1,0,1,1,1), 0, 0, 0, 20'h0FFF, 0, 0, 32'hFFFF, 1, "R3");
      drive(mk(1,0,1,0,1,1,1), 0, 1, 0, 20'h0FFF, 0, 0, 32'hFFFF, 1, "R3");
      drive(mk(1,0,1,0,1,1,1), 1, 1, 0, 20'h00001, 0, 1, 32'h2000, 3, "R3");
      idle(1);
      // R4 code and system type rules
      drive(CODE_RD, 0, 1, 0, 20'hFFFFF, 0, 1, 32'h0, 0, "R4");
      drive(mk(1,0,1,1,0,0,1), 0, 1, 0, 20'hFFFFF, 0, 0, 32'h0, 0, "R4");
      drive(CODE_RD, 0, 1, 0, 20'hFFFFF, 0, 0, 32'h0, 0, "R4");
      drive(DATA_RW, 0, 1, 0, 20'hFFFFF, 0, 2, 32'h0, 0, "R4");
      drive(mk(1,0,0,1,0,1,1), 0, 1, 0, 20'hFFFFF, 0, 0, 32'h0, 0, "R4");
      // R5 data type rules
      drive(mk(1,0,1,0,0,0,1), 0, 1, 0, 20'hFFFFF, 0, 1, 32'h0, 0, "R5");
      drive(mk(1,0,1,0,0,0,1), 0, 1, 0, 20'hFFFFF, 0, 0, 32'h0, 0, "R5");
      drive(DATA_RW, 0, 1, 0, 20'hFFFFF, 0, 1, 32'h0, 0, "R5");
      idle(1);
      // R6 non-conforming far jump
      drive(mk(1,2,1,1,0,1,1), 0, 1, 0, 20'hFFFFF, 3, 3, 32'h0, 0, "R6");
      drive(mk(1,2,1,1,0,1,1), 0, 1, 0, 20'hFFFFF, 2, 3, 32'h0, 0, "R6");
      drive(mk(1,2,1,1,0,1,1), 0, 1, 0, 20'hFFFFF, 1, 3, 32'h0, 0, "R6");
      // R7 conforming far jump
      drive(mk(1,2,1,1,1,1,1), 0, 1, 0, 20'hFFFFF, 3, 3, 32'h0, 0, "R7");
      drive(mk(1,2,1,1,1,1,1), 0, 1, 0, 20'hFFFFF, 0, 3, 32'h0, 0, "R7");
      drive(mk(1,2,1,1,1,1,1), 0, 1, 0, 20'hFFFFF, 2, 3, 32'h0, 0, "R7");
      idle(1);
      // R8 malformed
      drive(CODE_RD, 0, 1, 1, 20'hFFFFF, 0, 2, 32'h0, 0, "R8");
      drive(DATA_RW, 0, 0, 1, 20'hFFFFF, 0, 0, 32'h0, 0, "R8");
      drive(CODE_RD, 0, 0, 1, 20'hFFFFF, 0, 2, 32'h0, 0, "R8");
      // R9 not present
      drive(mk(0,0,1,0,0,1,0), 0, 1, 0, 20'hFFFFF, 0, 0, 32'h0, 0, "R9");
      // R10 priority
      drive(mk(0,0,1,1,0,0,0), 0, 1, 1, 20'h0, 0, 1, 32'h100, 0, "R10");
      drive(mk(1,0,1,1,0,0,0), 0, 1, 1, 20'h0, 0, 1, 32'h100, 0, "R10");
      drive(mk(1,2,1,0,0,0,0), 0, 1, 0, 20'h0, 0, 3, 32'h100, 0, "R10");
      drive(mk(1,2,1,1,1,1,0), 0, 1, 0, 20'h0, 0, 3, 32'h100, 0, "R10");
      idle(1);
      // R11 accessed-bit write-back
      drive(mk(1,0,1,0,0,1,0), 0, 1, 0, 20'hFFFFF, 0, 1, 32'h4, 0, "R11");
      drive(mk(1,0,1,0,0,1,1), 0, 1, 0, 20'hFFFFF, 0, 1, 32'h4, 0, "R11");
      drive(mk(1,0,1,0,0,0,0), 0, 1, 0, 20'hFFFFF, 0, 1, 32'h4, 0, "R11");
      idle(3);

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [31:0] off;
         logic [19:0] lim;
         lim = ($urandom_range(0, 1) == 0) ? 20'($urandom_range(0, 32)) : 20'($urandom);
         case ($urandom_range(0, 3))
            0: off = 32'($urandom_range(0, 40));
            1: off = 32'hFFFF - 32'($urandom_range(0, 4));
            2: off = {lim, 12'hFFF} - 32'($urandom_range(0, 3));
            default: off = $urandom;
         endcase
         drive(8'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 4) == 0),
               lim, 2'($urandom), 2'($urandom), off, 3'($urandom), "R10");
         if ($urandom_range(0, 5) == 0) idle(0);
      end
      idle(4);

      n_chk++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R12 missing responses: actual %0d pending expected 0", q.size());
      end
      summary();
   end
endmodule